// File: doc/BRIEF.md
# Pre-Encoded Radix-4 Booth Coefficient Multiplier

This block multiplies a signed two's-complement operand by one of a fixed set of coefficients held in a small internal table. The coefficients are not stored as plain binary. Each one is stored already recoded into radix-4 signed digits, with three control bits per digit. Because of this, the block has no digit recoding logic. The stored control bits drive the partial-product selectors directly.

On each clock the caller presents a table address and an operand. Both are registered together. The selected coefficient word forms one shifted partial product per digit, plus a row of correction carries for the negative digits. A carry-save array reduces these rows to a sum row and a carry row. A carry-lookahead adder merges the two rows, and the full-width signed result is registered. A new address and operand may be applied on every clock. The table contents come in through a parameter.

Top module: `pe_booth_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` becomes zero on that edge, whatever the other inputs are.
- R2: Digit j of a table word occupies bits [3j+2:3j], laid out as {neg, two, one}. Its value is 0 when one = two = 0, ±1 when one = 1, and ±2 when two = 1, negated when neg = 1. The bits one and two are never both set.
- R3: An address and operand that are present before rising edge t give their result on `product` after edge t+1. Until that edge, `product` keeps its previous value.
- R4: `product` equals the exact signed product of `a_in` (N+1 bits) and the selected coefficient value, in 2N+1 bits. This holds for all operands, including -2^N and 2^N-1.
- R5: A coefficient whose digits are all zero gives a zero product for every operand.
- R6: Negative digits produce the correct result. This includes coefficient -1 (lowest digit -1) and coefficient -2^(N-1) (top digit -2).
- R7: A different address and operand can be applied on every consecutive clock, and each result is correct.
- R8: The address selects table entry `coef_addr` out of the DEPTH entries packed into the table parameter. Entry e sits at bits [e*3N/2 +: 3N/2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| coef_addr | input | ADDR_W | Table entry selecting the coefficient |
| a_in | input | N+1 | Signed two's-complement operand |
| product | output | 2N+1 | Registered signed product |

## Verification
The assertions take three things for granted about the inputs. Every table word is a legal digit encoding, so one and two are never both set. Reset is held for at least one edge. The address and operand are known values from the first clock after reset. The stimulus keeps to these assumptions. It builds the table by recoding real N-bit coefficients and holds reset for several cycles. It then drives only defined operands on every clock: edge operands, a fixed set of values and a deterministic pseudo-random sequence.

// File: rtl/pe_booth_pkg.sv
package pe_booth_pkg;

    // One stored radix-4 digit: neg in the MSB, then two, then one.
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } bdigit_t;

    localparam int DIGIT_BITS = 3;

    // Signed value of a stored digit, for checking only.
    function automatic int digit_value(bdigit_t d);
        int mag;
        mag = d.two ? 2 : (d.one ? 1 : 0);
        return d.neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/pe_coef_rom.sv
module pe_coef_rom #(
    parameter int WORD_W = 12,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter logic [DEPTH*WORD_W-1:0] INIT = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (addr == ADDR_W'(e)) word = INIT[e*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/pe_ppgen.sv
module pe_ppgen
    import pe_booth_pkg::*;
#(
    parameter int N  = 8,
    parameter int K  = N / 2,
    parameter int PW = 2 * N + 1
) (
    input  logic [N:0]              a,
    input  bdigit_t [K-1:0]         digits,
    output logic [K-1:0][PW-1:0]    rows,
    output logic [PW-1:0]           corr
);
    localparam int MAG_W = N + 2;

    // Operand with a zero below the LSB and the sign repeated above the MSB.
    logic [N+2:0] ax;
    assign ax = {a[N], a, 1'b0};

    for (genvar j = 0; j < K; j++) begin : g_row
        logic [MAG_W-1:0] mag;
        logic [PW-1:0]    ext;
        always_comb begin
            for (int i = 0; i < MAG_W; i++) begin
                mag[i] = ((digits[j].one & ax[i+1]) | (digits[j].two & ax[i]))
                         ^ digits[j].neg;
            end
            ext = {{(PW-MAG_W){mag[MAG_W-1]}}, mag};
        end
        assign rows[j] = ext << (2 * j);
    end

    always_comb begin
        corr = '0;
        for (int j = 0; j < K; j++) corr[2*j] = digits[j].neg;
    end
endmodule

// File: rtl/pe_csa_array.sv
module pe_csa_array #(
    parameter int PW    = 17,
    parameter int NROWS = 5
) (
    input  logic [NROWS-1:0][PW-1:0] rows,
    output logic [PW-1:0]            sum_row,
    output logic [PW-1:0]            carry_row
);
    always_comb begin
        logic [PW-1:0] s;
        logic [PW-1:0] c;
        logic [PW-1:0] t;
        s = rows[0];
        c = rows[1];
        for (int r = 2; r < NROWS; r++) begin
            t = s ^ c ^ rows[r];
            c = ((s & c) | (s & rows[r]) | (c & rows[r])) << 1;
            s = t;
        end
        sum_row   = s;
        carry_row = c;
    end
endmodule

// File: rtl/pe_cla.sv
module pe_cla #(
    parameter int W   = 17,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    localparam int NG = (W + GRP - 1) / GRP;

    logic [W-1:0] g;
    logic [W-1:0] p;
    logic [W-1:0] cin;

    assign g = x & y;
    assign p = x ^ y;

    // Carries inside a group are written in lookahead form from the group carry-in.
    always_comb begin
        logic cg;
        logic acc;
        logic pr;
        cg  = 1'b0;
        cin = '0;
        for (int gi = 0; gi < NG; gi++) begin
            for (int b = 0; b <= GRP; b++) begin
                acc = 1'b0;
                pr  = 1'b1;
                for (int m = b - 1; m >= 0; m--) begin
                    if (gi * GRP + m < W) begin
                        acc = acc | (pr & g[gi*GRP+m]);
                        pr  = pr & p[gi*GRP+m];
                    end
                end
                acc = acc | (pr & cg);
                if (b < GRP && gi * GRP + b < W) cin[gi*GRP+b] = acc;
                if (b == GRP) cg = acc;
            end
        end
    end

    assign s = p ^ cin;
endmodule

// File: rtl/pe_booth_mult.sv
module pe_booth_mult
    import pe_booth_pkg::*;
#(
    parameter int N     = 8,
    parameter int DEPTH = 16,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter logic [DEPTH*(N/2)*3-1:0] ROM_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] coef_addr,
    input  logic [N:0]        a_in,
    output logic [2*N:0]      product
);
    localparam int K      = N / 2;
    localparam int WORD_W = K * DIGIT_BITS;
    localparam int PW     = 2 * N + 1;

    logic [ADDR_W-1:0]         addr_q;
    logic [N:0]                a_q;
    logic [WORD_W-1:0]         rom_word;
    bdigit_t [K-1:0]           digits;
    logic [K-1:0][PW-1:0]      pp_rows;
    logic [PW-1:0]             corr_row;
    logic [K:0][PW-1:0]        all_rows;
    logic [PW-1:0]             csa_sum;
    logic [PW-1:0]             csa_carry;
    logic [PW-1:0]             final_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            a_q     <= '0;
            product <= '0;
        end else begin
            addr_q  <= coef_addr;
            a_q     <= a_in;
            product <= final_sum;
        end
    end

    pe_coef_rom #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT(ROM_INIT)) u_rom (
        .addr (addr_q),
        .word (rom_word)
    );

    assign digits = rom_word;

    pe_ppgen #(.N(N), .K(K), .PW(PW)) u_ppgen (
        .a      (a_q),
        .digits (digits),
        .rows   (pp_rows),
        .corr   (corr_row)
    );

    assign all_rows = {corr_row, pp_rows};

    pe_csa_array #(.PW(PW), .NROWS(K + 1)) u_csa (
        .rows      (all_rows),
        .sum_row   (csa_sum),
        .carry_row (csa_carry)
    );

    pe_cla #(.W(PW), .GRP(4)) u_cla (
        .x (csa_sum),
        .y (csa_carry),
        .s (final_sum)
    );

    // ---------------- checking ----------------
    logic                 seen;
    logic signed [PW-1:0] coef_val;
    logic signed [PW-1:0] ref_prod;
    logic [PW-1:0]        row_total;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    always_comb begin
        coef_val = '0;
        for (int j = 0; j < K; j++) begin
            coef_val = coef_val + (PW'(digit_value(digits[j])) <<< (2 * j));
        end
        ref_prod = $signed({{(PW-N-1){a_q[N]}}, a_q}) * coef_val;
        row_total = '0;
        for (int r = 0; r <= K; r++) row_total = row_total + all_rows[r];
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> product == '0);

    for (genvar j = 0; j < K; j++) begin : g_legal
        p_digit_legal_r2: assert property (@(posedge clk) disable iff (rst)
            !(digits[j].one && digits[j].two));
    end

    p_exact_product_r4: assert property (@(posedge clk) disable iff (rst)
        seen |=> product == $past(ref_prod));

    p_csa_conserves_r4: assert property (@(posedge clk) disable iff (rst)
        (csa_sum + csa_carry) == row_total);

    p_zero_coef_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && coef_val == '0) |=> product == '0);

endmodule

// File: tb/pe_booth_mult_tb.sv
module pe_booth_mult_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 8;
    localparam int K      = N / 2;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 3 * K;
    localparam int PW     = 2 * N + 1;

    function automatic logic signed [N-1:0] coef_of(int e);
        case (e)
            0:  return 8'sd0;
            1:  return 8'sd1;
            2:  return -8'sd1;
            3:  return 8'sd127;
            4:  return -8'sd128;
            5:  return 8'sd85;
            6:  return -8'sd86;
            7:  return 8'sd2;
            8:  return -8'sd2;
            9:  return 8'sd3;
            10: return 8'sd64;
            11: return -8'sd64;
            12: return 8'sd42;
            13: return -8'sd43;
            14: return 8'sd100;
            default: return -8'sd7;
        endcase
    endfunction

    // Recode to radix-4 digits, stored as {neg, two, one} per digit (R2).
    function automatic logic [WORD_W-1:0] encode(logic signed [N-1:0] c);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int j = 0; j < K; j++) begin
            int d;
            int lo;
            lo = (j == 0) ? 0 : int'(c[2*j-1]);
            d = -2 * int'(c[2*j+1]) + int'(c[2*j]) + lo;
            w[3*j+2] = (d < 0);
            w[3*j+1] = (d == 2 || d == -2);
            w[3*j]   = (d == 1 || d == -1);
        end
        return w;
    endfunction

    function automatic logic [DEPTH*WORD_W-1:0] build_table();
        logic [DEPTH*WORD_W-1:0] t;
        for (int e = 0; e < DEPTH; e++) t[e*WORD_W +: WORD_W] = encode(coef_of(e));
        return t;
    endfunction

    localparam logic [DEPTH*WORD_W-1:0] TABLE = build_table();

    logic              clk;
    logic              rst;
    logic [ADDR_W-1:0] coef_addr;
    logic [N:0]        a_in;
    logic [PW-1:0]     product;

    pe_booth_mult #(.N(N), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROM_INIT(TABLE)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .coef_addr (coef_addr),
        .a_in      (a_in),
        .product   (product)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        int    exp;
        string req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares each result in the cycle it is due.
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, int'($signed(product)), e.exp);
            end
        end
    end

    task automatic drive(int e, logic signed [N:0] a, string req);
        exp_t x;
        @(negedge clk);
        coef_addr = ADDR_W'(e);
        a_in      = a;
        x.due = cyc + 2;
        x.exp = int'(a) * int'(coef_of(e));
        x.req = req;
        sb.push_back(x);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic signed [N:0] pats [7];
        pats = '{9'sd0, 9'sd1, -9'sd1, 9'sd255, -9'sd256, -9'sd170, 9'sd77};

        rst = 1'b1;
        coef_addr = 4'd3;
        a_in = 9'h0AB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'($signed(product)), 0);
        rst = 1'b0;

        // R2/R6: single negative digit cases, R5: zero coefficient
        drive(2, 9'sd37, "R2 coef -1");
        drive(4, -9'sd256, "R6 coef min x a min");
        drive(4, 9'sd255, "R6 coef min x a max");
        drive(0, -9'sd256, "R5 zero coef");
        drive(0, 9'sd255, "R5 zero coef");

        // R4/R8: every entry with a fixed set of operands, back to back
        for (int e = 0; e < DEPTH; e++) begin
            for (int p = 0; p < 7; p++) begin
                drive(e, pats[p], (coef_of(e) < 0) ? "R6 sweep" : "R8 sweep");
            end
        end
        drain();

        // R3: result appears only after the second edge
        drive(1, 9'sd50, "R3 first");
        drain();
        drive(1, -9'sd200, "R3 second");
        @(negedge clk);
        check("R3 held one cycle", int'($signed(product)), 50);
        drain();

        // R7: pseudo-random operands and addresses every cycle
        seed = 32'h1357_9BDF;
        for (int n = 0; n < 300; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            drive(int'(seed[27:24]), $signed(seed[20:12]), "R7 burst");
        end
        drain();

        // R4: extreme corners
        drive(3, 9'sd255, "R4 max x max");
        drive(3, -9'sd256, "R4 max x min");
        drive(6, -9'sd256, "R4 neg x min");
        drain();

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule